// File: doc/BRIEF.md
# Serial Frame-Sync Word Transmitter

This block sends one 32-bit word per frame over a three-wire synchronous serial link: a bit clock, an active-low frame sync and a serial data line. It runs from a fast system clock and makes the bit clock by dividing that clock by an even, programmable ratio. A word is handed over through a valid/ready handshake. Frame sync then goes low for one bit period. After a programmable delay of 0, 1 or 2 bit periods, the word is shifted out most significant bit first.

The delay and the half-period of the bit clock are held in a small configuration store that is written through a strobe. The store keeps both values inside their legal ranges. The transmitter copies the stored values when it accepts a word, so it can be reconfigured while a frame is on the wire. With the default parameters and a 64 MHz system clock, the half-period range of 2 to 8 system cycles gives bit rates from 4 MHz to 16 MHz. The reset value of 4 gives 8 MHz.

Top module: `fsx_word_tx`

## Requirements
- R1: Each frame carries exactly one 32-bit word and lasts exactly delay+32 bit periods. The bit clock has exactly one rising edge in each period.
- R2: Frame sync is low for exactly the first bit period of a frame. It falls in the same system cycle as the first rising edge of the bit clock.
- R3: The data delay takes the values 0, 1 or 2 and resets to 1. A written value of 3 is stored as 2.
- R4: The data line changes only together with a rising edge of the bit clock, or when the frame ends. Bit 31 is sent in period `delay` and bit 0 in period delay+31. With a delay of 0, bit 31 is on the line while frame sync is low. The line is low in the delay periods.
- R5: A bit period lasts 2*H system cycles, where H is the stored half-period. The bit clock is high for the first H cycles of the period and low for the last H. H resets to HALF_DEF.
- R6: A written half-period below HALF_MIN is stored as HALF_MIN. One above HALF_MAX is stored as HALF_MAX.
- R7: While idle, frame sync is high, the data line and the bit clock are low, and `ready_o` is high. `ready_o` is low during a frame.
- R8: Delay and half-period are sampled when a word is accepted. Configuration writes during a frame do not affect that frame; they take effect from the next frame.
- R9: `busy_o` is high from the cycle after acceptance until the end of the last bit period. `done_o` is high for exactly the one cycle that follows the last bit period.
- R10: `valid_i` asserted while a frame is running is ignored. The word it offers is neither sent nor queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Strobe that writes delay and half-period |
| cfg_dly_i | input | 2 | Data delay in bit periods (3 is clamped to 2) |
| cfg_half_i | input | 8 | Bit-clock half-period in system cycles (clamped) |
| word_i | input | 32 | Word to send |
| valid_i | input | 1 | Word offered |
| ready_o | output | 1 | Transmitter idle; a word can be taken |
| sclk_o | output | 1 | Bit clock |
| fs_n_o | output | 1 | Frame sync, active low |
| sd_o | output | 1 | Serial data |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse after the last bit |

## Verification
The assertions check the following on every cycle:
- frame sync falls only together with a bit-clock rising edge;
- data changes mid-frame only on bit-clock rising edges;
- the idle levels hold whenever `ready_o` is high;
- `done_o` is a single-cycle pulse;
- the stored settings stay within their ranges and stay stable during a frame.

Only the bench scenarios can show the rest:
- the actual bit order and the placement of the delay periods for each delay value;
- the exact period length after clamping;
- that a mid-frame configuration write or an ignored `valid_i` leaves the current frame unchanged.

The bench compares every output with a behavioural model on every cycle.

// File: rtl/fsx_pkg.sv
package fsx_pkg;
  localparam int WORD_W  = 32;
  localparam int DLY_W   = 2;
  localparam int DLY_MAX = 2;
  localparam int PER_W   = $clog2(WORD_W + DLY_MAX + 1);

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } tx_state_e;
endpackage

// File: rtl/fsx_cfg_store.sv
module fsx_cfg_store #(
  parameter int CFG_W    = 8,
  parameter int HALF_MIN = 2,
  parameter int HALF_MAX = 8,
  parameter int HALF_DEF = 4,
  parameter int HW       = $clog2(HALF_MAX + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [fsx_pkg::DLY_W-1:0] dly_i,
  input  logic [CFG_W-1:0]         half_i,
  output logic [fsx_pkg::DLY_W-1:0] dly_o,
  output logic [HW-1:0]            half_o
);
  import fsx_pkg::*;

  logic [DLY_W-1:0] dly_clamped;
  logic [HW-1:0]    half_clamped;

  always_comb begin
    dly_clamped = (int'(dly_i) > DLY_MAX) ? DLY_W'(DLY_MAX) : dly_i;
    if (int'(half_i) < HALF_MIN)      half_clamped = HW'(HALF_MIN);
    else if (int'(half_i) > HALF_MAX) half_clamped = HW'(HALF_MAX);
    else                              half_clamped = HW'(half_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_o  <= DLY_W'(1);
      half_o <= HW'(HALF_DEF);
    end else if (wr_i) begin
      dly_o  <= dly_clamped;
      half_o <= half_clamped;
    end
  end

  AST_DLY_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(dly_o) <= DLY_MAX);  // R3
  AST_HALF_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(half_o) >= HALF_MIN && int'(half_o) <= HALF_MAX);  // R6
endmodule

// File: rtl/fsx_bitclk.sv
module fsx_bitclk #(
  parameter int HALF_MAX = 8,
  parameter int HW       = $clog2(HALF_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [HW-1:0] half_i,
  output logic          sclk_o,
  output logic          period_end_o
);
  localparam int CW = HW + 1;

  logic [CW-1:0] phase_q;
  logic [CW-1:0] phase_top;

  assign phase_top = {half_i, 1'b0} - CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   phase_q <= '0;
    else if (!run_i)               phase_q <= '0;
    else if (phase_q == phase_top) phase_q <= '0;
    else                           phase_q <= phase_q + CW'(1);
  end

  assign sclk_o       = run_i && (phase_q < {1'b0, half_i});
  assign period_end_o = run_i && (phase_q == phase_top);

  AST_PERIOD_END_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end_o |-> !sclk_o);  // R5
endmodule

// File: rtl/fsx_frame.sv
module fsx_frame #(
  parameter int HALF_MAX = 8,
  parameter int HW       = $clog2(HALF_MAX + 1)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              valid_i,
  input  logic [fsx_pkg::WORD_W-1:0]        word_i,
  input  logic [fsx_pkg::DLY_W-1:0]         dly_cfg_i,
  input  logic [HW-1:0]                     half_cfg_i,
  input  logic                              period_end_i,
  output logic                              ready_o,
  output logic                              run_o,
  output logic [HW-1:0]                     half_o,
  output logic                              fs_n_o,
  output logic                              sd_o,
  output logic                              done_o
);
  import fsx_pkg::*;

  tx_state_e         state_q;
  logic [WORD_W-1:0] shift_q;
  logic [DLY_W-1:0]  dly_q;
  logic [PER_W-1:0]  per_q;
  logic [PER_W-1:0]  last_per;
  logic              accept;
  logic              in_data;

  assign ready_o  = (state_q == ST_IDLE);
  assign run_o    = (state_q == ST_RUN);
  assign accept   = ready_o && valid_i;
  assign last_per = PER_W'(dly_q) + PER_W'(WORD_W - 1);
  assign in_data  = per_q >= PER_W'(dly_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shift_q <= '0;
      dly_q   <= DLY_W'(1);
      half_o  <= HW'(1);
      per_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        state_q <= ST_RUN;
        shift_q <= word_i;
        dly_q   <= dly_cfg_i;
        half_o  <= half_cfg_i;
        per_q   <= '0;
      end else if (run_o && period_end_i) begin
        if (in_data) shift_q <= {shift_q[WORD_W-2:0], 1'b0};
        if (per_q == last_per) begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
        end else begin
          per_q <= per_q + PER_W'(1);
        end
      end
    end
  end

  assign fs_n_o = !(run_o && per_q == '0);
  assign sd_o   = run_o && in_data && shift_q[WORD_W-1];

  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o && $past(run_o) |-> $stable(dly_q) && $stable(half_o));  // R8
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R9
  AST_DONE_ENDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $fell(run_o));  // R9
endmodule

// File: rtl/fsx_word_tx.sv
module fsx_word_tx #(
  parameter int CFG_W    = 8,
  parameter int HALF_MIN = 2,
  parameter int HALF_MAX = 8,
  parameter int HALF_DEF = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_wr_i,
  input  logic [1:0]  cfg_dly_i,
  input  logic [7:0]  cfg_half_i,
  input  logic [31:0] word_i,
  input  logic        valid_i,
  output logic        ready_o,
  output logic        sclk_o,
  output logic        fs_n_o,
  output logic        sd_o,
  output logic        busy_o,
  output logic        done_o
);
  import fsx_pkg::*;

  localparam int HW = $clog2(HALF_MAX + 1);

  logic [DLY_W-1:0] dly_cfg;
  logic [HW-1:0]    half_cfg;
  logic [HW-1:0]    half_run;
  logic             run;
  logic             period_end;

  fsx_cfg_store #(
    .CFG_W(CFG_W), .HALF_MIN(HALF_MIN), .HALF_MAX(HALF_MAX),
    .HALF_DEF(HALF_DEF), .HW(HW)
  ) i_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(cfg_wr_i),
    .dly_i(cfg_dly_i), .half_i(CFG_W'(cfg_half_i)),
    .dly_o(dly_cfg), .half_o(half_cfg)
  );

  fsx_frame #(.HALF_MAX(HALF_MAX), .HW(HW)) i_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .word_i(word_i),
    .dly_cfg_i(dly_cfg), .half_cfg_i(half_cfg), .period_end_i(period_end),
    .ready_o(ready_o), .run_o(run), .half_o(half_run),
    .fs_n_o(fs_n_o), .sd_o(sd_o), .done_o(done_o)
  );

  fsx_bitclk #(.HALF_MAX(HALF_MAX), .HW(HW)) i_bitclk (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .half_i(half_run),
    .sclk_o(sclk_o), .period_end_o(period_end)
  );

  assign busy_o = run;

  AST_FS_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fs_n_o) |-> $rose(sclk_o));  // R2
  AST_DATA_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) && !$stable(sd_o) |-> $rose(sclk_o));  // R4
  AST_IDLE_LEVELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> fs_n_o && !sd_o && !sclk_o && !busy_o);  // R7
endmodule

// File: tb/test_fsx_word_tx.sv
module test_fsx_word_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_dly = '0;
  logic [7:0]  cfg_half = '0;
  logic [31:0] word = '0;
  logic        valid = 1'b0;
  logic        ready, sclk, fs_n, sd, busy, done;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  string scen = "R7";

  // model state
  int  m_dly = 1, m_half = 4;
  bit  m_run = 0, m_done = 0;
  int  m_t = 0, m_fd = 0, m_fh = 0;
  logic [31:0] m_word = '0;
  int  rise_cnt = 0;
  bit  sclk_prev = 0;

  always #4 clk = ~clk;

  fsx_word_tx i_fsx_word_tx (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_dly_i(cfg_dly),
    .cfg_half_i(cfg_half), .word_i(word), .valid_i(valid), .ready_o(ready),
    .sclk_o(sclk), .fs_n_o(fs_n), .sd_o(sd), .busy_o(busy), .done_o(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s/%s t=%0t actual=%0h expected=%0h", req, scen, $time, act, exp);
    end
  endtask

  // behavioural reference, R3 R5 R6 clamp and R8 sampling
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dly = 1; m_half = 4; m_run = 0; m_done = 0; m_t = 0;
    end else begin
      m_done = 0;
      if (m_run) begin
        m_t++;
        if (m_t == 2 * m_fh * (m_fd + 32)) begin m_run = 0; m_done = 1; end
      end else if (valid) begin
        m_run = 1; m_t = 0; m_fd = m_dly; m_fh = m_half; m_word = word;
      end
      if (cfg_wr) begin
        m_dly  = (cfg_dly > 2) ? 2 : int'(cfg_dly);
        m_half = (cfg_half < 2) ? 2 : (cfg_half > 8) ? 8 : int'(cfg_half);
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      int per, ph;
      bit e_sclk, e_fs, e_sd;
      per = m_run ? m_t / (2 * m_fh) : 0;
      ph  = m_run ? m_t % (2 * m_fh) : 0;
      e_sclk = m_run && ph < m_fh;
      e_fs   = !(m_run && per == 0);
      e_sd   = m_run && per >= m_fd && per - m_fd <= 31 && m_word[31 - (per - m_fd)];
      check("R5", 32'(sclk), 32'(e_sclk));
      check("R2", 32'(fs_n), 32'(e_fs));
      check("R4", 32'(sd), 32'(e_sd));
      check("R7", 32'(ready), 32'(!m_run));
      check("R9_busy", 32'(busy), 32'(m_run));
      check("R9_done", 32'(done), 32'(m_done));
      if (sclk && !sclk_prev) rise_cnt++;
      sclk_prev = sclk;
      if (done) begin
        check("R1", 32'(rise_cnt), 32'(m_fd + 32));
        rise_cnt = 0;
      end
    end
  end

  task automatic cfg_write(input logic [1:0] d, input logic [7:0] h);
    @(negedge clk); cfg_wr = 1; cfg_dly = d; cfg_half = h;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    while (!ready) @(negedge clk);
    valid = 1; word = w;
    @(negedge clk); valid = 0;
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    scen = "R7_reset";
    check("R7", {29'd0, ready, fs_n, sd}, 32'b110);
    rst_n = 1;
    scen = "R3_default"; send(32'hA5C3_0F81);
    cfg_write(2'd0, 8'd4); scen = "R4_delay0"; send(32'h8000_0001);
    cfg_write(2'd2, 8'd3); scen = "R1_delay2"; send(32'h1234_5678);
    cfg_write(2'd3, 8'd5); scen = "R3_clamp"; send(32'hFFFF_0000);
    cfg_write(2'd1, 8'd0); scen = "R6_low"; send(32'hDEAD_BEEF);
    cfg_write(2'd1, 8'd200); scen = "R6_high"; send(32'h0F0F_F0F0);
    // R8: reconfigure mid-frame
    scen = "R8";
    fork
      send(32'hCAFE_0123);
      begin repeat (20) @(negedge clk); cfg_write(2'd0, 8'd2); end
    join
    send(32'h7654_3210);
    // R10: valid while busy, then back-to-back
    scen = "R10";
    fork
      send(32'h5555_AAAA);
      begin
        repeat (10) @(negedge clk);
        valid = 1; word = 32'hFFFF_FFFF;
        repeat (5) @(negedge clk);
        valid = 0;
      end
    join
    send(32'h0000_0001);
    repeat (5) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule